// File: doc/BRIEF.md
# Privilege-Gated Event Counter Bank

This block holds a few 32-bit event counters. Each counter has an event selector that picks one line of an event pulse vector, and the counter adds one on every clock in which that line is high. Software never addresses a counter directly. A selector register names one counter, and a single count window then reads or loads that counter. A companion window reads or writes the selected counter's event choice.

Every register access carries a privilege flag. Privileged accesses are always honoured. Unprivileged accesses to the counter registers are honoured only while a software-controlled user-enable bit is set. The user-enable register can be read from any mode but written only with privilege. A refused access changes nothing, returns zero and raises a one-cycle undefined-access fault.

Register indices on `addr_i` are 0 for the selector, 1 for the count window, 2 for the event-choice window and 3 for user-enable. Indices 4 to 7 are unmapped.

Top module: `perf_cnt_bank`

## Requirements
- R1: After reset (asynchronous, active low), all counters, event choices, the selector and the user-enable bit are 0, and `rdata_o` and `fault_o` are 0.
- R2: Register 0 stores the low 2 bits of the write data as the selector. A read returns that value with all higher bits 0.
- R3: A read of register 1 returns the selected counter's value, and a write loads that counter with `wdata_i`. Read data appears on `rdata_o` one cycle after the request and is 0 after a write.
- R4: Register 2 holds a 3-bit event choice for the selected counter. Counter k adds 1 on each cycle in which `evt_i[choice_k]` is 1.
- R5: A counter at 0xFFFFFFFF that counts an event becomes 0.
- R6: When a load and a counted event hit the same counter in the same cycle, the counter takes the loaded value.
- R7: With a selector value of 3, reads of registers 1 and 2 return 0 and writes to them change no counter.
- R8: Register 3 holds the user-enable bit in bit 0. Bits 31:1 read as 0, and a privileged write stores `wdata_i[0]`.
- R9: An unprivileged access to registers 0 to 2 while user-enable is 0 sets `fault_o` the next cycle, returns 0 and changes no state.
- R10: An unprivileged read of register 3 is allowed without a fault. An unprivileged write to it faults and leaves it unchanged.
- R11: While user-enable is 1, unprivileged accesses to registers 0 to 2 behave as privileged ones and do not fault.
- R12: Privileged accesses and accesses to unmapped registers 4 to 7 never fault, and unmapped reads return 0. `fault_o` is high for exactly one cycle per refused access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| priv_i | input | 1 | 1 = privileged access |
| addr_i | input | 3 | Register index |
| wdata_i | input | 32 | Write data |
| evt_i | input | 8 | Event pulse lines |
| rdata_o | output | 32 | Registered read data |
| fault_o | output | 1 | Undefined-access fault pulse |

## Verification
Read data and the fault pulse are both due one cycle after the access: they are registered at the edge that samples the request. The bench drives each access on a falling edge and compares `rdata_o` and `fault_o` at the next falling edge. An event pulse held for one cycle adds one at the rising edge inside that cycle. Counts are therefore read back by a window access issued afterwards. Every other cycle keeps the event lines at 0 so that the expected counts stay exact. The single-cycle width of the fault is checked by sampling one further falling edge.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int REG_SEL = 0;
  localparam int REG_CNT = 1;
  localparam int REG_EVS = 2;
  localparam int REG_UEN = 3;

  typedef struct packed {
    logic wr_sel;
    logic wr_cnt;
    logic wr_evs;
    logic wr_uen;
    logic rd_ok;
    logic deny;
  } pmu_ctl_t;
endpackage

// File: rtl/pmu_access_gate.sv
module pmu_access_gate
  import pmu_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic              priv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              uen_i,
  output pmu_ctl_t          ctl_o
);
  logic is_pmu, is_uen, deny, grant;

  assign is_pmu = (addr_i == ADDR_W'(REG_SEL)) || (addr_i == ADDR_W'(REG_CNT)) ||
                  (addr_i == ADDR_W'(REG_EVS));
  assign is_uen = (addr_i == ADDR_W'(REG_UEN));
  // user mode: pmu regs need enable, uen is read-only
  assign deny   = req_i && !priv_i && ((is_pmu && !uen_i) || (is_uen && we_i));
  assign grant  = req_i && !deny;

  always_comb begin
    ctl_o        = '0;
    ctl_o.deny   = deny;
    ctl_o.rd_ok  = grant && !we_i;
    ctl_o.wr_sel = grant && we_i && (addr_i == ADDR_W'(REG_SEL));
    ctl_o.wr_cnt = grant && we_i && (addr_i == ADDR_W'(REG_CNT));
    ctl_o.wr_evs = grant && we_i && (addr_i == ADDR_W'(REG_EVS));
    ctl_o.wr_uen = grant && we_i && is_uen;
  end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 8,
  localparam int ES_W   = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               ld_cnt_i,
  input  logic               ld_evs_i,
  input  logic [CNT_W-1:0]   wdata_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [ES_W-1:0]    evs_o
);
  logic hit;

  always_comb begin
    hit = 1'b0;
    for (int e = 0; e < NUM_EVT; e++)
      if (evs_o == ES_W'(e)) hit = evt_i[e];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      evs_o <= '0;
    end else begin
      if (ld_cnt_i)  cnt_o <= wdata_i;           // load beats event
      else if (hit)  cnt_o <= cnt_o + 1'b1;      // wraps naturally
      if (ld_evs_i)  evs_o <= wdata_i[ES_W-1:0];
    end
  end
endmodule

// File: rtl/perf_cnt_bank.sv
module perf_cnt_bank
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 3,
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 8,
  parameter int ADDR_W  = 3,
  localparam int SEL_W  = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1,
  localparam int ES_W   = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic               priv_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [CNT_W-1:0]   wdata_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic [CNT_W-1:0]   rdata_o,
  output logic               fault_o
);
  pmu_ctl_t         ctl;
  logic [SEL_W-1:0] sel_q;
  logic             uen_q;
  logic [CNT_W-1:0] cnt [NUM_CNT];
  logic [ES_W-1:0]  evs [NUM_CNT];
  logic [CNT_W-1:0] cnt_win, evs_win, rd_mux;

  pmu_access_gate #(.ADDR_W(ADDR_W)) u_gate (
    .req_i  (req_i),
    .we_i   (we_i),
    .priv_i (priv_i),
    .addr_i (addr_i),
    .uen_i  (uen_q),
    .ctl_o  (ctl)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    logic sel_k;
    assign sel_k = (sel_q == SEL_W'(k));
    pmu_counter #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (evt_i),
      .ld_cnt_i (ctl.wr_cnt && sel_k),
      .ld_evs_i (ctl.wr_evs && sel_k),
      .wdata_i  (wdata_i),
      .cnt_o    (cnt[k]),
      .evs_o    (evs[k])
    );
  end

  // selectors beyond NUM_CNT-1 see zero
  always_comb begin
    cnt_win = '0;
    evs_win = '0;
    for (int k = 0; k < NUM_CNT; k++)
      if (sel_q == SEL_W'(k)) begin
        cnt_win = cnt[k];
        evs_win = CNT_W'(evs[k]);
      end
  end

  always_comb begin
    rd_mux = '0;
    if (ctl.rd_ok) begin
      case (addr_i)
        ADDR_W'(REG_SEL): rd_mux = CNT_W'(sel_q);
        ADDR_W'(REG_CNT): rd_mux = cnt_win;
        ADDR_W'(REG_EVS): rd_mux = evs_win;
        ADDR_W'(REG_UEN): rd_mux = CNT_W'(uen_q);
        default:          rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      uen_q   <= 1'b0;
      rdata_o <= '0;
      fault_o <= 1'b0;
    end else begin
      if (ctl.wr_sel) sel_q <= wdata_i[SEL_W-1:0];
      if (ctl.wr_uen) uen_q <= wdata_i[0];
      rdata_o <= rd_mux;
      fault_o <= ctl.deny;
    end
  end
endmodule

// File: rtl/pmu_bank_chk.sv
module pmu_bank_chk #(
  parameter int NUM_CNT = 3,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 3,
  parameter int SEL_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic              priv_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [CNT_W-1:0]  rdata_i,
  input logic              fault_i,
  input logic              uen_i,
  input logic [SEL_W-1:0]  sel_i
);
  logic user_pmu;
  assign user_pmu = req_i && !priv_i && (addr_i < ADDR_W'(3));

  p_priv_no_fault_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && priv_i |=> !fault_i);

  p_idle_no_fault_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !fault_i);

  p_user_denied_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_pmu && !uen_i |=> fault_i && (rdata_i == '0));

  p_user_allowed_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_pmu && uen_i |=> !fault_i);

  p_uen_user_wr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && !priv_i && (addr_i == ADDR_W'(3)) |=> fault_i && $stable(uen_i));

  p_uen_high_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && (addr_i == ADDR_W'(3)) |=> (rdata_i[CNT_W-1:1] == '0));

  p_oor_window_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && priv_i && (addr_i == ADDR_W'(1)) && (sel_i >= SEL_W'(NUM_CNT))
    |=> rdata_i == '0);

  p_denied_sel_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_pmu && !uen_i |=> $stable(sel_i));
endmodule

bind perf_cnt_bank pmu_bank_chk #(
  .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .priv_i  (priv_i),
  .addr_i  (addr_i),
  .rdata_i (rdata_o),
  .fault_i (fault_o),
  .uen_i   (uen_q),
  .sel_i   (sel_q)
);

// File: tb/perf_cnt_bank_bench.sv
module perf_cnt_bank_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        we;
    logic        priv;
    logic [2:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp_rd;
    logic        exp_flt;
    logic [3:0]  req;
  } vec_t;

  // walked in order; state carries from row to row
  localparam vec_t TBL [25] = '{
    '{1'b0, 1'b0, 3'd3, 32'h0,          32'h0,          1'b0, 4'd10}, // R10 user read uen
    '{1'b0, 1'b0, 3'd1, 32'h0,          32'h0,          1'b1, 4'd9},  // R9
    '{1'b1, 1'b0, 3'd1, 32'h5,          32'h0,          1'b1, 4'd9},  // R9
    '{1'b0, 1'b1, 3'd1, 32'h0,          32'h0,          1'b0, 4'd9},  // R9 no effect
    '{1'b1, 1'b0, 3'd3, 32'h1,          32'h0,          1'b1, 4'd10}, // R10 user wr uen
    '{1'b0, 1'b1, 3'd3, 32'h0,          32'h0,          1'b0, 4'd10}, // R10 unchanged
    '{1'b1, 1'b1, 3'd1, 32'h1234_5678,  32'h0,          1'b0, 4'd3},  // R3
    '{1'b1, 1'b1, 3'd0, 32'h2,          32'h0,          1'b0, 4'd2},  // R2
    '{1'b1, 1'b1, 3'd1, 32'hCAFE_0002,  32'h0,          1'b0, 4'd3},  // R3
    '{1'b0, 1'b1, 3'd0, 32'h0,          32'h2,          1'b0, 4'd2},  // R2
    '{1'b0, 1'b1, 3'd1, 32'h0,          32'hCAFE_0002,  1'b0, 4'd3},  // R3
    '{1'b1, 1'b1, 3'd0, 32'hFFFF_FFF0,  32'h0,          1'b0, 4'd2},  // R2 low bits only
    '{1'b0, 1'b1, 3'd0, 32'h0,          32'h0,          1'b0, 4'd2},  // R2
    '{1'b0, 1'b1, 3'd1, 32'h0,          32'h1234_5678,  1'b0, 4'd3},  // R3
    '{1'b1, 1'b1, 3'd3, 32'hFFFF_FFFF,  32'h0,          1'b0, 4'd8},  // R8
    '{1'b0, 1'b0, 3'd3, 32'h0,          32'h1,          1'b0, 4'd8},  // R8 high bits zero
    '{1'b0, 1'b0, 3'd1, 32'h0,          32'h1234_5678,  1'b0, 4'd11}, // R11
    '{1'b1, 1'b0, 3'd0, 32'h3,          32'h0,          1'b0, 4'd11}, // R11
    '{1'b0, 1'b1, 3'd1, 32'h0,          32'h0,          1'b0, 4'd7},  // R7
    '{1'b1, 1'b1, 3'd1, 32'hDEAD,       32'h0,          1'b0, 4'd7},  // R7
    '{1'b1, 1'b1, 3'd0, 32'h1,          32'h0,          1'b0, 4'd7},  // R7
    '{1'b0, 1'b1, 3'd1, 32'h0,          32'h0,          1'b0, 4'd7},  // R7 counter1 untouched
    '{1'b0, 1'b0, 3'd5, 32'h0,          32'h0,          1'b0, 4'd12}, // R12 unmapped
    '{1'b1, 1'b1, 3'd3, 32'h0,          32'h0,          1'b0, 4'd8},  // R8 clear
    '{1'b0, 1'b0, 3'd0, 32'h0,          32'h0,          1'b1, 4'd9}   // R9
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, priv_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [7:0]  evt_i = '0;
  logic [31:0] rdata_o;
  logic        fault_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  perf_cnt_bank u_perf_cnt_bank (
    .clk_i, .rst_ni, .req_i, .we_i, .priv_i, .addr_i, .wdata_i, .evt_i, .rdata_o, .fault_o
  );

  task automatic check(input int r, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  // drive on falling edge, result registered at next rising edge, sample at next falling edge
  task automatic access(input logic w, input logic p, input logic [2:0] a,
                        input logic [31:0] d, input logic [7:0] ev);
    @(negedge clk_i);
    req_i = 1'b1; we_i = w; priv_i = p; addr_i = a; wdata_i = d; evt_i = ev;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; evt_i = '0;
  endtask

  task automatic rd_chk(input int r, input logic p, input logic [2:0] a,
                        input logic [31:0] exp, input string what);
    access(1'b0, p, a, 32'h0, 8'h0);
    check(r, what, rdata_o, exp);
  endtask

  task automatic pulse(input logic [7:0] ev, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      evt_i = ev;
    end
    @(negedge clk_i);
    evt_i = '0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(1, "reset rdata", rdata_o, 32'h0);                 // R1
    check(1, "reset fault", {31'h0, fault_o}, 32'h0);        // R1

    for (int i = 0; i < 25; i++) begin
      access(TBL[i].we, TBL[i].priv, TBL[i].addr, TBL[i].wdata, 8'h0);
      check(int'(TBL[i].req), $sformatf("row %0d rdata", i), rdata_o, TBL[i].exp_rd);
      check(int'(TBL[i].req), $sformatf("row %0d fault", i), {31'h0, fault_o}, {31'h0, TBL[i].exp_flt});
    end
    // R12 pulse width after the faulting last row
    @(negedge clk_i);
    check(12, "fault single cycle", {31'h0, fault_o}, 32'h0);

    // R4 event selection; counters: c0=12345678, c1=0, c2=CAFE0002
    access(1'b1, 1'b1, 3'd0, 32'h1, 8'h0);
    access(1'b1, 1'b1, 3'd2, 32'h4, 8'h0);
    access(1'b1, 1'b1, 3'd0, 32'h2, 8'h0);
    access(1'b1, 1'b1, 3'd2, 32'h6, 8'h0);
    access(1'b1, 1'b1, 3'd1, 32'h0, 8'h0);
    pulse(8'h10, 3);
    pulse(8'h40, 1);
    pulse(8'h01, 2);
    pulse(8'h80, 2);                                          // chosen by nobody
    rd_chk(4, 1'b1, 3'd1, 32'h1, "counter2 count");           // R4
    rd_chk(4, 1'b1, 3'd2, 32'h6, "counter2 choice");          // R4
    access(1'b1, 1'b1, 3'd0, 32'h1, 8'h0);
    rd_chk(4, 1'b1, 3'd1, 32'h3, "counter1 count");           // R4
    rd_chk(4, 1'b1, 3'd2, 32'h4, "counter1 choice");          // R4
    access(1'b1, 1'b1, 3'd0, 32'h0, 8'h0);
    rd_chk(4, 1'b1, 3'd1, 32'h1234_567A, "counter0 count");   // R4

    // R7 event-choice window with out-of-range selector
    access(1'b1, 1'b1, 3'd0, 32'h3, 8'h0);
    access(1'b1, 1'b1, 3'd2, 32'h7, 8'h0);
    rd_chk(7, 1'b1, 3'd2, 32'h0, "oor choice read");
    access(1'b1, 1'b1, 3'd0, 32'h0, 8'h0);
    rd_chk(7, 1'b1, 3'd2, 32'h0, "counter0 choice untouched");

    // R5 wrap
    access(1'b1, 1'b1, 3'd1, 32'hFFFF_FFFF, 8'h0);
    pulse(8'h01, 1);
    rd_chk(5, 1'b1, 3'd1, 32'h0, "wrap");

    // R6 load wins over same-cycle event
    access(1'b1, 1'b1, 3'd1, 32'h100, 8'h01);
    rd_chk(6, 1'b1, 3'd1, 32'h100, "load beats event");

    // R1 asynchronous reset mid-run
    access(1'b1, 1'b1, 3'd3, 32'h1, 8'h0);
    #(CLK_PERIOD/4) rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    rd_chk(1, 1'b1, 3'd1, 32'h0, "counter cleared");
    rd_chk(1, 1'b1, 3'd3, 32'h0, "uen cleared");
    access(1'b0, 1'b0, 3'd1, 32'h0, 8'h0);
    check(1, "user fault after reset", {31'h0, fault_o}, 32'h1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule